// File: doc/BRIEF.md
# USB IN Endpoint Handshake Controller

This block keeps the transmit-side state of a set of device endpoints and chooses the answer to every IN token the host sends. For each endpoint it stores a buffer identifier, a byte count, a ready flag, a stall flag, an isochronous flag, a sticky "sent" flag, a sticky "cancelled" flag and the data toggle. When a token arrives it replies one cycle later with either a data response (buffer, clamped length and DATA0/DATA1 PID), a NAK or a STALL. It then waits for the host's handshake. Packet memory and line serialisation belong to the neighbouring blocks.

Firmware loads an endpoint through one write port, which updates the buffer, size, ready, stall and isochronous settings together. Hardware completes or cancels what was queued. An ACK retires the buffer and advances the toggle. A SETUP on an endpoint, or a bus reset, withdraws a queued buffer and marks the withdrawal in a cancelled flag that stays set until firmware clears it. The sent flag and the cancelled flag are cleared by one-cycle strobes.

Top module: `usb_in_hs`

## Requirements
- R1: After reset every per-endpoint flag (ready, stall, sent, cancelled) and every response and event output is 0, and each data toggle is DATA0.
- R2: An IN token gets a STALL response (code 3) if the endpoint's stall flag is set, whatever its ready flag holds, and also if the endpoint number is NEP or above. For NAK and STALL the buffer, length and PID outputs are 0.
- R3: An IN token to an endpoint that is not stalled and whose ready flag is clear gets a NAK response (code 2).
- R4: An IN token to a ready, unstalled endpoint gets a data response (code 1) carrying the endpoint's buffer ID and a length equal to its size, with sizes above 64 reported as 64 and size 0 reported as 0. Every response is a one-cycle rsp_valid_o pulse in the cycle after the token. When rsp_valid_o is low, all response fields are 0.
- R5: A handshake of code 0 (ACK) on a pending non-isochronous data response clears the endpoint's ready flag, sets its sent flag, pulses sent_evt_o for one cycle and flips its toggle, so the next data response carries rsp_pid1_o = 1.
- R6: A handshake of code 1 (timeout) ends the wait without events. The ready flag stays set and the toggle is unchanged, so a retried token resends the same PID.
- R7: A handshake of code 2 or 3 (bad packet or bad CRC) on a pending response, or a new IN token while a response is pending, pulses in_err_o. Ready and toggle are left unchanged, and the new token is answered normally.
- R8: A data response from an isochronous endpoint awaits no handshake. In the response cycle the ready flag clears, the sent flag sets and sent_evt_o pulses, and the toggle stays unchanged.
- R9: A SETUP strobe on an endpoint clears its ready and stall flags and sets its cancelled flag if ready was set. A token in the same cycle sees the cleared state. A firmware write in the same cycle takes effect over the cleared fields.
- R10: A bus reset clears every ready flag, and sets the cancelled flag of each endpoint whose ready flag was set.
- R11: The sent and cancelled flags hold until their clear strobe. If hardware sets a flag in the same cycle as its clear strobe, the flag ends up set.
- R12: A toggle-clear strobe returns the endpoint's toggle to DATA0, and this wins over a flip from an ACK in the same cycle.
- R13: A SETUP on the awaited endpoint, or a bus reset, abandons the wait. A handshake in that cycle or later then causes no sent flag, no event and no toggle change.
- R14: A handshake arriving while no data response is pending has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ep_wr_i | input | 1 | Firmware write strobe for one endpoint |
| ep_wr_sel_i | input | 4 | Endpoint written |
| ep_wr_buf_i | input | 5 | Buffer ID to store |
| ep_wr_size_i | input | 7 | Byte count to store |
| ep_wr_rdy_i | input | 1 | Ready value to store |
| ep_wr_stall_i | input | 1 | Stall value to store |
| ep_wr_iso_i | input | 1 | Isochronous value to store |
| sent_clr_i | input | 12 | Per-endpoint sent-flag clear strobes |
| pend_clr_i | input | 12 | Per-endpoint cancelled-flag clear strobes |
| tog_clr_i | input | 12 | Per-endpoint toggle-to-DATA0 strobes |
| setup_seen_i | input | 12 | Per-endpoint SETUP-accepted strobes |
| bus_reset_i | input | 1 | Bus reset strobe |
| tok_in_i | input | 1 | IN token received |
| tok_ep_i | input | 4 | Endpoint addressed by the token |
| hs_valid_i | input | 1 | Host handshake outcome valid |
| hs_code_i | input | 2 | 0 ACK, 1 timeout, 2 bad packet, 3 bad CRC |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_code_o | output | 2 | 1 data, 2 NAK, 3 STALL |
| rsp_buf_o | output | 5 | Buffer ID to send |
| rsp_len_o | output | 7 | Bytes to send (at most 64) |
| rsp_pid1_o | output | 1 | 1 for DATA1, 0 for DATA0 |
| sent_evt_o | output | 1 | Packet-delivered pulse |
| in_err_o | output | 1 | IN transaction dropped pulse |
| rdy_o | output | 12 | Ready flags |
| sent_o | output | 12 | Sent flags |
| pend_o | output | 12 | Cancelled flags |
| stall_o | output | 12 | Stall flags |

## Verification
The collision of interest is an ACK for an outstanding data packet arriving in the same cycle as a SETUP strobe, or a bus reset, that withdraws that same endpoint's buffer. The bench drives the handshake and the cancelling strobe together after a data response, then sends a second ACK after that. It expects the ready flag to clear and the cancelled flag to set, with no sent flag, no sent event and no toggle change, which the next data response reveals through its PID. Strobe-versus-set collisions on the sent, cancelled and toggle state are provoked the same way and judged against a behavioural model on every clock.

// File: rtl/usb_in_hs_pkg.sv
package usb_in_hs_pkg;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_DATA  = 2'd1,
        RSP_NAK   = 2'd2,
        RSP_STALL = 2'd3
    } rsp_kind_e;

    typedef enum logic [1:0] {
        HS_ACK     = 2'd0,
        HS_TIMEOUT = 2'd1,
        HS_BADPKT  = 2'd2,
        HS_BADCRC  = 2'd3
    } hs_kind_e;

endpackage

// File: rtl/usb_in_ep_slot.sv
module usb_in_ep_slot #(
    parameter int BUF_W  = 5,
    parameter int SIZE_W = 7
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  logic [BUF_W-1:0]  wr_buf_i,
    input  logic [SIZE_W-1:0] wr_size_i,
    input  logic              wr_rdy_i,
    input  logic              wr_stall_i,
    input  logic              wr_iso_i,
    input  logic              setup_i,
    input  logic              bus_reset_i,
    input  logic              done_i,
    input  logic              flip_i,
    input  logic              sent_clr_i,
    input  logic              pend_clr_i,
    input  logic              tog_clr_i,
    output logic [BUF_W-1:0]  buf_o,
    output logic [SIZE_W-1:0] size_o,
    output logic              rdy_o,
    output logic              stall_o,
    output logic              iso_o,
    output logic              sent_o,
    output logic              pend_o,
    output logic              tog_o
);

    typedef struct packed {
        logic [BUF_W-1:0]  bufid;
        logic [SIZE_W-1:0] size;
        logic              rdy;
        logic              stall;
        logic              iso;
        logic              sent;
        logic              pend;
        logic              tog;
    } slot_t;

    slot_t st_d, st_q;
    logic  withdraw;

    assign withdraw = setup_i | bus_reset_i;

    always_comb begin
        st_d = st_q;

        // sticky flags: a hardware set beats a same-cycle clear
        st_d.pend = (st_q.pend & ~pend_clr_i) | (withdraw & st_q.rdy);
        st_d.sent = (st_q.sent & ~sent_clr_i) | done_i;

        if (withdraw || done_i) begin
            st_d.rdy = 1'b0;
        end
        if (setup_i) begin
            st_d.stall = 1'b0;
        end

        if (flip_i) begin
            st_d.tog = ~st_q.tog;
        end
        if (tog_clr_i) begin
            st_d.tog = 1'b0;
        end

        // firmware write lands on top of hardware updates
        if (wr_i) begin
            st_d.bufid = wr_buf_i;
            st_d.size  = wr_size_i;
            st_d.rdy   = wr_rdy_i;
            st_d.stall = wr_stall_i;
            st_d.iso   = wr_iso_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign buf_o   = st_q.bufid;
    assign size_o  = st_q.size;
    assign rdy_o   = st_q.rdy;
    assign stall_o = st_q.stall;
    assign iso_o   = st_q.iso;
    assign sent_o  = st_q.sent;
    assign pend_o  = st_q.pend;
    assign tog_o   = st_q.tog;

endmodule

// File: rtl/usb_in_rsp_pick.sv
module usb_in_rsp_pick
    import usb_in_hs_pkg::*;
#(
    parameter int BUF_W   = 5,
    parameter int SIZE_W  = 7,
    parameter int MAX_PKT = 64
) (
    input  logic              in_range_i,
    input  logic              stall_i,
    input  logic              rdy_i,
    input  logic [BUF_W-1:0]  buf_i,
    input  logic [SIZE_W-1:0] size_i,
    input  logic              tog_i,
    output rsp_kind_e         kind_o,
    output logic [BUF_W-1:0]  buf_o,
    output logic [SIZE_W-1:0] len_o,
    output logic              pid1_o
);

    localparam logic [SIZE_W-1:0] LEN_CAP = SIZE_W'(MAX_PKT);

    always_comb begin
        kind_o = RSP_NAK;
        buf_o  = '0;
        len_o  = '0;
        pid1_o = 1'b0;
        if (!in_range_i || stall_i) begin
            kind_o = RSP_STALL;
        end else if (rdy_i) begin
            kind_o = RSP_DATA;
            buf_o  = buf_i;
            len_o  = (size_i > LEN_CAP) ? LEN_CAP : size_i;
            pid1_o = tog_i;
        end
    end

endmodule

// File: rtl/usb_in_hs.sv
module usb_in_hs
    import usb_in_hs_pkg::*;
#(
    parameter int NEP     = 12,
    parameter int BUF_W   = 5,
    parameter int SIZE_W  = 7,
    parameter int MAX_PKT = 64,
    localparam int EP_W   = $clog2(NEP)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ep_wr_i,
    input  logic [EP_W-1:0]   ep_wr_sel_i,
    input  logic [BUF_W-1:0]  ep_wr_buf_i,
    input  logic [SIZE_W-1:0] ep_wr_size_i,
    input  logic              ep_wr_rdy_i,
    input  logic              ep_wr_stall_i,
    input  logic              ep_wr_iso_i,
    input  logic [NEP-1:0]    sent_clr_i,
    input  logic [NEP-1:0]    pend_clr_i,
    input  logic [NEP-1:0]    tog_clr_i,
    input  logic [NEP-1:0]    setup_seen_i,
    input  logic              bus_reset_i,
    input  logic              tok_in_i,
    input  logic [EP_W-1:0]   tok_ep_i,
    input  logic              hs_valid_i,
    input  logic [1:0]        hs_code_i,
    output logic              rsp_valid_o,
    output logic [1:0]        rsp_code_o,
    output logic [BUF_W-1:0]  rsp_buf_o,
    output logic [SIZE_W-1:0] rsp_len_o,
    output logic              rsp_pid1_o,
    output logic              sent_evt_o,
    output logic              in_err_o,
    output logic [NEP-1:0]    rdy_o,
    output logic [NEP-1:0]    sent_o,
    output logic [NEP-1:0]    pend_o,
    output logic [NEP-1:0]    stall_o
);

    typedef struct packed {
        logic              waiting;
        logic [EP_W-1:0]   wait_ep;
        logic              rsp_valid;
        rsp_kind_e         rsp_kind;
        logic [BUF_W-1:0]  rsp_buf;
        logic [SIZE_W-1:0] rsp_len;
        logic              rsp_pid1;
        logic              sent_evt;
        logic              err_evt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NEP-1:0]    rdy_v, stall_v, iso_v, sent_v, pend_v, tog_v;
    logic [NEP-1:0]    wr_hit_v, done_v, flip_v, cancel_v;
    logic [BUF_W-1:0]  buf_a  [NEP];
    logic [SIZE_W-1:0] size_a [NEP];

    logic              in_range;
    logic [EP_W-1:0]   sel;
    logic              wait_cut;
    rsp_kind_e         pick_kind;
    logic [BUF_W-1:0]  pick_buf;
    logic [SIZE_W-1:0] pick_len;
    logic              pick_pid1;

    assign cancel_v = setup_seen_i | {NEP{bus_reset_i}};
    assign in_range = ({1'b0, tok_ep_i} < (EP_W+1)'(NEP));
    assign sel      = in_range ? tok_ep_i : '0;

    for (genvar g = 0; g < NEP; g++) begin : g_ep
        assign wr_hit_v[g] = ep_wr_i && (ep_wr_sel_i == EP_W'(g));

        usb_in_ep_slot #(
            .BUF_W  (BUF_W),
            .SIZE_W (SIZE_W)
        ) u_slot (
            .clk_i       (clk_i),
            .rst_ni      (rst_ni),
            .wr_i        (wr_hit_v[g]),
            .wr_buf_i    (ep_wr_buf_i),
            .wr_size_i   (ep_wr_size_i),
            .wr_rdy_i    (ep_wr_rdy_i),
            .wr_stall_i  (ep_wr_stall_i),
            .wr_iso_i    (ep_wr_iso_i),
            .setup_i     (setup_seen_i[g]),
            .bus_reset_i (bus_reset_i),
            .done_i      (done_v[g]),
            .flip_i      (flip_v[g]),
            .sent_clr_i  (sent_clr_i[g]),
            .pend_clr_i  (pend_clr_i[g]),
            .tog_clr_i   (tog_clr_i[g]),
            .buf_o       (buf_a[g]),
            .size_o      (size_a[g]),
            .rdy_o       (rdy_v[g]),
            .stall_o     (stall_v[g]),
            .iso_o       (iso_v[g]),
            .sent_o      (sent_v[g]),
            .pend_o      (pend_v[g]),
            .tog_o       (tog_v[g])
        );
    end

    // the token sees the endpoint with this cycle's withdrawals applied
    usb_in_rsp_pick #(
        .BUF_W   (BUF_W),
        .SIZE_W  (SIZE_W),
        .MAX_PKT (MAX_PKT)
    ) u_pick (
        .in_range_i (in_range),
        .stall_i    (stall_v[sel] & ~setup_seen_i[sel]),
        .rdy_i      (rdy_v[sel] & ~cancel_v[sel]),
        .buf_i      (buf_a[sel]),
        .size_i     (size_a[sel]),
        .tog_i      (tog_v[sel]),
        .kind_o     (pick_kind),
        .buf_o      (pick_buf),
        .len_o      (pick_len),
        .pid1_o     (pick_pid1)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.rsp_valid = 1'b0;
        ctl_d.rsp_kind  = RSP_IDLE;
        ctl_d.rsp_buf   = '0;
        ctl_d.rsp_len   = '0;
        ctl_d.rsp_pid1  = 1'b0;
        ctl_d.sent_evt  = 1'b0;
        ctl_d.err_evt   = 1'b0;
        done_v          = '0;
        flip_v          = '0;
        wait_cut        = ctl_q.waiting && cancel_v[ctl_q.wait_ep];

        if (tok_in_i) begin
            ctl_d.waiting = 1'b0;
            if (ctl_q.waiting && !wait_cut) begin
                ctl_d.err_evt = 1'b1;
            end
            ctl_d.rsp_valid = 1'b1;
            ctl_d.rsp_kind  = pick_kind;
            ctl_d.rsp_buf   = pick_buf;
            ctl_d.rsp_len   = pick_len;
            ctl_d.rsp_pid1  = pick_pid1;
            if (pick_kind == RSP_DATA) begin
                if (iso_v[sel]) begin
                    done_v[sel]    = 1'b1;
                    ctl_d.sent_evt = 1'b1;
                end else begin
                    ctl_d.waiting = 1'b1;
                    ctl_d.wait_ep = sel;
                end
            end
        end else if (ctl_q.waiting) begin
            if (wait_cut) begin
                ctl_d.waiting = 1'b0;
            end else if (hs_valid_i) begin
                ctl_d.waiting = 1'b0;
                if (hs_code_i == HS_ACK) begin
                    done_v[ctl_q.wait_ep] = 1'b1;
                    flip_v[ctl_q.wait_ep] = 1'b1;
                    ctl_d.sent_evt        = 1'b1;
                end else if (hs_code_i != HS_TIMEOUT) begin
                    ctl_d.err_evt = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rsp_valid_o = ctl_q.rsp_valid;
    assign rsp_code_o  = ctl_q.rsp_kind;
    assign rsp_buf_o   = ctl_q.rsp_buf;
    assign rsp_len_o   = ctl_q.rsp_len;
    assign rsp_pid1_o  = ctl_q.rsp_pid1;
    assign sent_evt_o  = ctl_q.sent_evt;
    assign in_err_o    = ctl_q.err_evt;
    assign rdy_o       = rdy_v;
    assign sent_o      = sent_v;
    assign pend_o      = pend_v;
    assign stall_o     = stall_v;

endmodule

// File: rtl/usb_in_hs_chk.sv
module usb_in_hs_chk #(
    parameter int NEP     = 12,
    parameter int SIZE_W  = 7,
    parameter int MAX_PKT = 64
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              ep_wr_i,
    input logic [NEP-1:0]    setup_seen_i,
    input logic              bus_reset_i,
    input logic              tok_in_i,
    input logic              hs_valid_i,
    input logic              rsp_valid_o,
    input logic [1:0]        rsp_code_o,
    input logic [SIZE_W-1:0] rsp_len_o,
    input logic              sent_evt_o,
    input logic [NEP-1:0]    rdy_o,
    input logic [NEP-1:0]    sent_o,
    input logic [NEP-1:0]    pend_o
);

    p_rsp_from_tok_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_valid_o |-> $past(tok_in_i))
        else $error("response without a token");

    p_len_cap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && rsp_code_o == 2'd1) |-> (rsp_len_o <= SIZE_W'(MAX_PKT)))
        else $error("data length above the packet limit");

    p_sent_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(sent_o & ~$past(sent_o))) |-> sent_evt_o)
        else $error("sent flag rose without a sent event");

    p_evt_cause_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sent_evt_o |-> $past(tok_in_i || hs_valid_i))
        else $error("sent event without token or handshake");

    p_pend_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(pend_o & ~$past(pend_o))) |-> $past(bus_reset_i || (|setup_seen_i)))
        else $error("cancelled flag rose without SETUP or bus reset");

    p_reset_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(bus_reset_i && !ep_wr_i) |-> (rdy_o == '0))
        else $error("ready flag survived a bus reset");

endmodule

bind usb_in_hs usb_in_hs_chk #(
    .NEP     (NEP),
    .SIZE_W  (SIZE_W),
    .MAX_PKT (MAX_PKT)
) u_chk (.*);

// File: tb/test_usb_in_hs.sv
`timescale 1ns/1ps
module test_usb_in_hs;

    localparam int NEP = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ep_wr = 1'b0;
    logic [3:0]  ep_wr_sel = '0;
    logic [4:0]  ep_wr_buf = '0;
    logic [6:0]  ep_wr_size = '0;
    logic        ep_wr_rdy = 1'b0, ep_wr_stall = 1'b0, ep_wr_iso = 1'b0;
    logic [11:0] sent_clr = '0, pend_clr = '0, tog_clr = '0, setup_seen = '0;
    logic        bus_reset = 1'b0;
    logic        tok_in = 1'b0;
    logic [3:0]  tok_ep = '0;
    logic        hs_valid = 1'b0;
    logic [1:0]  hs_code = '0;

    logic        rsp_valid, rsp_pid1, sent_evt, in_err;
    logic [1:0]  rsp_code;
    logic [4:0]  rsp_buf;
    logic [6:0]  rsp_len;
    logic [11:0] rdy, sent, pend, stall;

    usb_in_hs i_usb_in_hs (
        .clk_i(clk), .rst_ni(rst_n),
        .ep_wr_i(ep_wr), .ep_wr_sel_i(ep_wr_sel), .ep_wr_buf_i(ep_wr_buf),
        .ep_wr_size_i(ep_wr_size), .ep_wr_rdy_i(ep_wr_rdy),
        .ep_wr_stall_i(ep_wr_stall), .ep_wr_iso_i(ep_wr_iso),
        .sent_clr_i(sent_clr), .pend_clr_i(pend_clr), .tog_clr_i(tog_clr),
        .setup_seen_i(setup_seen), .bus_reset_i(bus_reset),
        .tok_in_i(tok_in), .tok_ep_i(tok_ep),
        .hs_valid_i(hs_valid), .hs_code_i(hs_code),
        .rsp_valid_o(rsp_valid), .rsp_code_o(rsp_code), .rsp_buf_o(rsp_buf),
        .rsp_len_o(rsp_len), .rsp_pid1_o(rsp_pid1), .sent_evt_o(sent_evt),
        .in_err_o(in_err), .rdy_o(rdy), .sent_o(sent), .pend_o(pend),
        .stall_o(stall)
    );

    always #2 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    bit    chk_on = 1'b0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    bit m_rdy [NEP], m_stall [NEP], m_iso [NEP], m_sent [NEP], m_pend [NEP], m_tog [NEP];
    int m_buf [NEP], m_size [NEP];
    int m_wait = -1;
    int e_valid, e_code, e_buf, e_len, e_pid, e_sent_evt, e_err;
    bit cancel [NEP], done [NEP], flip [NEP];
    bit wcut, s_ok, r_ok;
    int ep;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NEP; i++) begin
                m_rdy[i] = 0; m_stall[i] = 0; m_iso[i] = 0; m_sent[i] = 0;
                m_pend[i] = 0; m_tog[i] = 0; m_buf[i] = 0; m_size[i] = 0;
            end
            m_wait = -1;
            e_valid = 0; e_code = 0; e_buf = 0; e_len = 0; e_pid = 0; e_sent_evt = 0; e_err = 0;
        end else begin
            e_valid = 0; e_code = 0; e_buf = 0; e_len = 0; e_pid = 0; e_sent_evt = 0; e_err = 0;
            for (int i = 0; i < NEP; i++) begin
                cancel[i] = setup_seen[i] | bus_reset;
                done[i] = 0;
                flip[i] = 0;
            end
            wcut = (m_wait >= 0) && cancel[m_wait];
            ep = int'(tok_ep);
            if (tok_in) begin
                if (m_wait >= 0 && !wcut) e_err = 1;
                m_wait = -1;
                e_valid = 1;
                if (ep >= NEP) begin
                    e_code = 3;
                end else begin
                    s_ok = m_stall[ep] && !setup_seen[ep];
                    r_ok = m_rdy[ep] && !cancel[ep];
                    if (s_ok) e_code = 3;
                    else if (!r_ok) e_code = 2;
                    else begin
                        e_code = 1;
                        e_buf = m_buf[ep];
                        e_len = (m_size[ep] > 64) ? 64 : m_size[ep];
                        e_pid = m_tog[ep];
                        if (m_iso[ep]) begin
                            done[ep] = 1;
                            e_sent_evt = 1;
                        end else begin
                            m_wait = ep;
                        end
                    end
                end
            end else if (m_wait >= 0) begin
                if (wcut) begin
                    m_wait = -1;
                end else if (hs_valid) begin
                    if (hs_code == 0) begin
                        done[m_wait] = 1;
                        flip[m_wait] = 1;
                        e_sent_evt = 1;
                    end else if (hs_code != 1) begin
                        e_err = 1;
                    end
                    m_wait = -1;
                end
            end
            for (int i = 0; i < NEP; i++) begin
                if (pend_clr[i]) m_pend[i] = 0;
                if (cancel[i] && m_rdy[i]) m_pend[i] = 1;
                if (sent_clr[i]) m_sent[i] = 0;
                if (done[i]) m_sent[i] = 1;
                if (cancel[i] || done[i]) m_rdy[i] = 0;
                if (setup_seen[i]) m_stall[i] = 0;
                if (flip[i]) m_tog[i] = ~m_tog[i];
                if (tog_clr[i]) m_tog[i] = 0;
                if (ep_wr && int'(ep_wr_sel) == i) begin
                    m_buf[i] = int'(ep_wr_buf);
                    m_size[i] = int'(ep_wr_size);
                    m_rdy[i] = ep_wr_rdy;
                    m_stall[i] = ep_wr_stall;
                    m_iso[i] = ep_wr_iso;
                end
            end
        end
    end

    function automatic int pack(input bit v [NEP]);
        int r = 0;
        for (int i = 0; i < NEP; i++) if (v[i]) r = r | (1 << i);
        return r;
    endfunction

    task automatic cmp(input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (chk_on) begin
            cmp("rsp_valid", int'(rsp_valid), e_valid);
            cmp("rsp_code", int'(rsp_code), e_code);
            cmp("rsp_buf", int'(rsp_buf), e_buf);
            cmp("rsp_len", int'(rsp_len), e_len);
            cmp("rsp_pid1", int'(rsp_pid1), e_pid);
            cmp("sent_evt", int'(sent_evt), e_sent_evt);
            cmp("in_err", int'(in_err), e_err);
            cmp("rdy", int'(rdy), pack(m_rdy));
            cmp("sent", int'(sent), pack(m_sent));
            cmp("pend", int'(pend), pack(m_pend));
            cmp("stall", int'(stall), pack(m_stall));
        end
    end

    task automatic nxt();
        @(negedge clk);
        ep_wr = 0; tok_in = 0; hs_valid = 0; bus_reset = 0;
        sent_clr = '0; pend_clr = '0; tog_clr = '0; setup_seen = '0;
    endtask

    task automatic set_wr(input int e, input int b, input int s, input bit r, input bit st, input bit iso);
        ep_wr = 1; ep_wr_sel = 4'(e); ep_wr_buf = 5'(b); ep_wr_size = 7'(s);
        ep_wr_rdy = r; ep_wr_stall = st; ep_wr_iso = iso;
    endtask

    task automatic wr(input int e, input int b, input int s, input bit r, input bit st, input bit iso);
        set_wr(e, b, s, r, st, iso);
        nxt();
    endtask

    task automatic tok(input int e);
        tok_in = 1; tok_ep = 4'(e);
        nxt();
    endtask

    task automatic hs(input int c);
        hs_valid = 1; hs_code = 2'(c);
        nxt();
    endtask

    task automatic gap(input int n);
        repeat (n) nxt();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(4 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        @(posedge clk);
        @(negedge clk);
        chk_on = 1;
        gap(3);
        rst_n = 1;
        gap(2);

        cur_req = "R3";
        tok(2); gap(1);

        cur_req = "R4";
        wr(1, 7, 10, 1, 0, 0); tok(1); gap(1); hs(1);
        wr(0, 3, 100, 1, 0, 0); tok(0); hs(1);
        wr(0, 3, 0, 1, 0, 0); tok(0); hs(1);
        wr(0, 4, 64, 1, 0, 0); tok(0); hs(1);
        wr(0, 5, 65, 1, 0, 0); tok(0); hs(1);
        wr(0, 6, 127, 1, 0, 0); tok(0); hs(1); gap(1);

        cur_req = "R5";
        tok(1); hs(0); gap(1);
        wr(1, 8, 5, 1, 0, 0); tok(1); hs(0); gap(1);

        cur_req = "R6";
        wr(7, 2, 3, 1, 0, 0); tok(7); hs(1); tok(7); hs(1); tok(7); hs(0); gap(1);

        cur_req = "R7";
        wr(8, 11, 9, 1, 0, 0); tok(8); hs(2); tok(8); hs(3);
        tok(8); tok(8); hs(0); gap(1);

        cur_req = "R14";
        hs(0); hs(2); hs(1); gap(1);

        cur_req = "R2";
        wr(3, 12, 8, 1, 1, 0); tok(3); tok(13); tok(15); gap(1);

        cur_req = "R8";
        wr(4, 9, 20, 1, 0, 1); tok(4); hs(0); tok(4); gap(1);

        cur_req = "R9";
        wr(5, 14, 30, 1, 1, 0);
        setup_seen[5] = 1; tok_in = 1; tok_ep = 4'd5; nxt(); gap(1);
        wr(9, 1, 2, 1, 0, 0);
        setup_seen[9] = 1; set_wr(9, 2, 4, 1, 1, 0); nxt(); tok(9); gap(1);

        cur_req = "R10";
        wr(0, 1, 1, 1, 0, 0); wr(2, 2, 2, 1, 0, 0); wr(11, 3, 3, 1, 0, 0);
        bus_reset = 1; nxt(); tok(2); gap(1);

        cur_req = "R11";
        pend_clr = 12'hfff; nxt(); sent_clr = 12'h002; nxt();
        wr(1, 5, 5, 1, 0, 0); tok(1);
        hs_valid = 1; hs_code = 0; sent_clr[1] = 1; nxt(); gap(1);
        wr(2, 6, 6, 1, 0, 0);
        setup_seen[2] = 1; pend_clr[2] = 1; nxt(); gap(1);

        cur_req = "R12";
        wr(10, 7, 7, 1, 0, 0); tok(10); hs(0);
        tog_clr[10] = 1; nxt();
        wr(10, 7, 7, 1, 0, 0); tok(10);
        hs_valid = 1; hs_code = 0; tog_clr[10] = 1; nxt();
        wr(10, 7, 7, 1, 0, 0); tok(10); hs(1); gap(1);

        cur_req = "R13";
        wr(6, 13, 40, 1, 0, 0); tok(6);
        hs_valid = 1; hs_code = 0; setup_seen[6] = 1; nxt(); hs(0);
        wr(6, 13, 40, 1, 0, 0); tok(6);
        bus_reset = 1; hs_valid = 1; hs_code = 0; nxt(); hs(0);
        wr(6, 13, 40, 1, 0, 0); tok(6);
        setup_seen[11] = 1; nxt(); hs(0);
        wr(6, 13, 40, 1, 0, 0); tok(6); hs(1); gap(2);

        finished = 1;
        summary();
        $finish;
    end

endmodule